// File: doc/BRIEF.md
# Down-Counting Watchdog with Selectable Timeout Response

This block is a down-counting watchdog for a CPU subsystem. A programmable reload value is held in a small register that software writes through a plain write strobe. The first time the block is enabled, it copies the reload value into the counter. After that, the counter steps down by one on every cycle where the timer tick enable is high. Software keeps the watchdog alive by pulsing a refresh strobe, which copies the reload value into the counter again.

If the count is zero on a tick and no refresh arrives in that cycle, the watchdog times out. A static configuration input chooses the response to a timeout. In reset mode the block issues a one-cycle system reset request. In interrupt mode it issues a one-cycle interrupt request and sets a sticky timeout flag. If a timeout in interrupt mode happens while the low-power stop input is high, the block also issues a one-cycle wake-up recovery request and sets a second sticky flag that marks the stop state.

After any timeout the counter wraps to all-ones and keeps counting down. A status-read strobe clears both sticky flags. The watchdog oscillator, the interrupt controller and the reset sequencer all sit outside this block. All pins are plain control and status signals with no back-pressure.

Top module: `wdog_core`

## Requirements
- R1: After reset, the counter and the reload register are all-ones, all three request outputs are 0, and both sticky flags are 0.
- R2: In the first cycle after reset in which `enable` is high, the counter loads the reload value and does not decrement. Later re-enables do not reload the counter.
- R3: While the block is enabled and loaded, each cycle with `tick` high decrements the counter by exactly one. Cycles with `tick` low leave it unchanged.
- R4: While the block is enabled and loaded, a `refresh` pulse loads the reload value in that cycle, whether or not `tick` is high. When `refresh` and a zero-count tick happen in the same cycle, the refresh wins and no timeout occurs.
- R5: A timeout is a cycle that has `tick` high, a count of zero and no refresh. In the following cycle the counter reads all-ones, and it keeps decrementing on later ticks.
- R6: With `reset_mode`=1, a timeout gives a `rst_req` pulse exactly one cycle wide. It gives no `irq_req`, no `wake_req`, and does not change either flag.
- R7: With `reset_mode`=0, a timeout gives an `irq_req` pulse exactly one cycle wide and sets `flag_wdt` in the same cycle that the pulse appears.
- R8: With `reset_mode`=0 and `stop_mode`=1 at the timeout, the block also pulses `wake_req` for one cycle and sets `flag_stop`. With `stop_mode`=0 it does neither.
- R9: A `stat_rd` strobe clears `flag_wdt` and `flag_stop` in the next cycle. If a new flag-setting timeout happens in the same cycle as the strobe, that flag reads 1.
- R10: While `enable` is low, the counter holds its value, `refresh` and `tick` are ignored, and no request is issued.
- R11: A `reg_wr` pulse stores `reg_wdata` as the reload value. The store does not change the current count, and the new value is used by the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Watchdog enable |
| tick | input | 1 | Timer tick enable; one decrement per high cycle |
| refresh | input | 1 | Refresh strobe from the CPU |
| reset_mode | input | 1 | Static timeout response: 1 = reset request, 0 = interrupt request |
| stop_mode | input | 1 | High while the system is in the low-power stop state |
| reg_wr | input | 1 | Reload register write strobe |
| reg_wdata | input | CW | Reload value to write |
| stat_rd | input | 1 | Status read strobe; clears the sticky flags |
| count | output | CW | Current counter value |
| rst_req | output | 1 | One-cycle system reset request |
| irq_req | output | 1 | One-cycle interrupt request |
| wake_req | output | 1 | One-cycle stop-recovery request |
| flag_wdt | output | 1 | Sticky interrupt-mode timeout flag |
| flag_stop | output | 1 | Sticky flag: the timeout happened in the stop state |

## Verification
The assertions check these properties on every cycle:
- the count holds while the block is disabled;
- the first enable and every refresh load the reload value;
- the counter wraps to all-ones after a timeout;
- a reset request and an interrupt request never appear together;
- each request pulse is one cycle wide, and a wake request only comes with an interrupt request;
- a status read clears the flags.

Only the bench scenarios can show the exact number of ticks from load to timeout for each reload value. They also show the correct response in all four combinations of `reset_mode` and `stop_mode`, and that the refresh wins against a zero-count tick. Finally, they show that re-enabling does not reload the counter and that a write to the reload register is only used at the next load.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Timeout event passed from the counter to the response logic
  typedef struct packed {
    logic hit;       // timeout in this cycle
    logic as_reset;  // response selected: reset request
    logic in_stop;   // stop state active at the timeout
  } wdog_evt_t;

endpackage

// File: rtl/wdog_reload.sv
module wdog_reload #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] value
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     value <= '1;
    else if (wr_en) value <= wr_data;
  end

  assert_write_stores_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> value == $past(wr_data));

endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          tick,
  input  logic          refresh,
  input  logic [CW-1:0] reload,
  input  logic          reset_mode,
  input  logic          stop_mode,
  output logic [CW-1:0] count,
  output wdog_evt_t     evt
);

  logic armed;   // set once the first enable has loaded the counter
  logic at_zero;

  assign at_zero = (count == '0);

  always_comb begin
    evt.hit      = enable && armed && !refresh && tick && at_zero;
    evt.as_reset = reset_mode;
    evt.in_stop  = stop_mode;
  end

  // Decrementing zero gives all-ones, which is the wrap after a timeout
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '1;
      armed <= 1'b0;
    end else if (enable) begin
      if (!armed) begin
        count <= reload;
        armed <= 1'b1;
      end else if (refresh) begin
        count <= reload;
      end else if (tick) begin
        count <= count - 1'b1;
      end
    end
  end

  assert_first_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !armed) |=> (armed && count == $past(reload)));

  assert_refresh_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && armed && refresh) |=> count == $past(reload));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt.hit |=> count == '1);

  assert_hold_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(count));

endmodule

// File: rtl/wdog_resp.sv
module wdog_resp
  import wdog_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  wdog_evt_t evt,
  input  logic      stat_rd,
  output logic      rst_req,
  output logic      irq_req,
  output logic      wake_req,
  output logic      flag_wdt,
  output logic      flag_stop
);

  logic to_irq, to_stop;

  assign to_irq  = evt.hit && !evt.as_reset;
  assign to_stop = to_irq && evt.in_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req   <= 1'b0;
      irq_req   <= 1'b0;
      wake_req  <= 1'b0;
      flag_wdt  <= 1'b0;
      flag_stop <= 1'b0;
    end else begin
      rst_req  <= evt.hit && evt.as_reset;
      irq_req  <= to_irq;
      wake_req <= to_stop;
      // a new set beats a clearing read in the same cycle
      if (to_irq)       flag_wdt <= 1'b1;
      else if (stat_rd) flag_wdt <= 1'b0;
      if (to_stop)      flag_stop <= 1'b1;
      else if (stat_rd) flag_stop <= 1'b0;
    end
  end

  assert_one_response_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && irq_req));

  assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_irq_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> flag_wdt);

  assert_wake_with_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (irq_req && flag_stop));

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !evt.hit) |=> (!flag_wdt && !flag_stop));

endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          tick,
  input  logic          refresh,
  input  logic          reset_mode,
  input  logic          stop_mode,
  input  logic          reg_wr,
  input  logic [CW-1:0] reg_wdata,
  input  logic          stat_rd,
  output logic [CW-1:0] count,
  output logic          rst_req,
  output logic          irq_req,
  output logic          wake_req,
  output logic          flag_wdt,
  output logic          flag_stop
);

  logic [CW-1:0] reload;
  wdog_evt_t     evt;

  wdog_reload #(.CW(CW)) u_reload (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_data(reg_wdata), .value(reload)
  );

  wdog_count #(.CW(CW)) u_count (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .refresh(refresh),
    .reload(reload), .reset_mode(reset_mode), .stop_mode(stop_mode),
    .count(count), .evt(evt)
  );

  wdog_resp u_resp (
    .clk(clk), .rst_n(rst_n), .evt(evt), .stat_rd(stat_rd),
    .rst_req(rst_req), .irq_req(irq_req), .wake_req(wake_req),
    .flag_wdt(flag_wdt), .flag_stop(flag_stop)
  );

  assert_wrap_after_timeout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || irq_req) |-> count == '1);

  assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !(rst_req || irq_req || wake_req));

endmodule

// File: tb/test_wdog_core.sv
module test_wdog_core;
  localparam int CW  = 5;
  localparam int TOP = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic enable = 0, tick = 0, refresh = 0, reset_mode = 0, stop_mode = 0;
  logic reg_wr = 0, stat_rd = 0;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] count;
  logic rst_req, irq_req, wake_req, flag_wdt, flag_stop;
  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  wdog_core #(.CW(CW)) i_wdog_core (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .refresh(refresh),
    .reset_mode(reset_mode), .stop_mode(stop_mode), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .stat_rd(stat_rd), .count(count), .rst_req(rst_req),
    .irq_req(irq_req), .wake_req(wake_req), .flag_wdt(flag_wdt), .flag_stop(flag_stop)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_req(input string tag, input int r, input int i, input int w);
    chk(tag, int'(rst_req), r);
    chk(tag, int'(irq_req), i);
    chk(tag, int'(wake_req), w);
  endtask

  task automatic do_reset();
    enable = 0; tick = 0; refresh = 0; reg_wr = 0; stat_rd = 0;
    rst_n = 0;
    cyc(); cyc();
    rst_n = 1;
  endtask

  task automatic load(input int v);
    reg_wr = 1; reg_wdata = CW'(v);
    cyc();
    reg_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // reset state
    chk("R1 count", int'(count), TOP);
    chk_req("R1 req", 0, 0, 0);
    chk("R1 flag_wdt", int'(flag_wdt), 0);
    chk("R1 flag_stop", int'(flag_stop), 0);
    enable = 1; cyc();
    chk("R1 reload reset value", int'(count), TOP);

    // sweep every reload value and every mode pair
    for (int r = 0; r <= TOP; r++) begin
      logic m, s;
      m = r[0]; s = r[1];
      do_reset();
      load(r);
      reset_mode = m; stop_mode = s;
      enable = 1; cyc();
      chk("R2 first load", int'(count), r);
      tick = 1;
      for (int k = 0; k < r; k++) begin
        cyc();
        chk("R3 decrement", int'(count), r - 1 - k);
        chk_req("R5 early", 0, 0, 0);
      end
      cyc();
      chk("R5 wrap", int'(count), TOP);
      chk_req(m ? "R6 reset pulse" : "R7 R8 irq pulse", int'(m), int'(!m), int'(!m && s));
      chk("R7 flag_wdt", int'(flag_wdt), int'(!m));
      chk("R8 flag_stop", int'(flag_stop), int'(!m && s));
      cyc();
      chk("R5 keeps counting", int'(count), TOP - 1);
      chk_req("R6 R7 single cycle", 0, 0, 0);
      tick = 0;
    end

    // tick gaps, refresh, refresh versus zero
    do_reset();
    reset_mode = 0; stop_mode = 0;
    load(10);
    enable = 1; cyc();
    for (int k = 0; k < 3; k++) begin cyc(); chk("R3 hold without tick", int'(count), 10); end
    tick = 1; cyc(); tick = 0; cyc();
    chk("R3 one tick", int'(count), 9);
    refresh = 1; cyc(); refresh = 0;
    chk("R4 refresh without tick", int'(count), 10);
    tick = 1; repeat (10) cyc();
    chk("R4 at zero", int'(count), 0);
    refresh = 1; cyc(); refresh = 0; tick = 0;
    chk("R4 refresh wins", int'(count), 10);
    chk_req("R4 no timeout", 0, 0, 0);
    cyc();
    chk_req("R4 no late timeout", 0, 0, 0);

    // reload write does not touch the count
    load(3);
    chk("R11 count unchanged", int'(count), 10);
    refresh = 1; cyc(); refresh = 0;
    chk("R11 new value used", int'(count), 3);

    // disabled behaviour and re-enable
    enable = 0; tick = 1; refresh = 1;
    load(7);
    for (int k = 0; k < 3; k++) begin cyc(); chk("R10 hold", int'(count), 3); end
    refresh = 0; tick = 0;
    enable = 1; cyc();
    chk("R2 no reload on re-enable", int'(count), 3);
    tick = 1; repeat (3) cyc();
    chk("R10 reached zero", int'(count), 0);
    enable = 0;
    for (int k = 0; k < 2; k++) begin
      cyc();
      chk("R10 no timeout while off", int'(count), 0);
      chk_req("R10 quiet", 0, 0, 0);
    end

    // flags: read clear and set-beats-clear
    stop_mode = 1; enable = 1; cyc(); tick = 0;
    chk_req("R8 stop timeout", 0, 1, 1);
    chk("R8 flag_stop set", int'(flag_stop), 1);
    cyc();
    chk("R9 flag sticky", int'(flag_wdt), 1);
    stat_rd = 1; cyc(); stat_rd = 0;
    chk("R9 flag_wdt cleared", int'(flag_wdt), 0);
    chk("R9 flag_stop cleared", int'(flag_stop), 0);
    stop_mode = 0;
    load(0);
    refresh = 1; cyc(); refresh = 0;
    chk("R4 reload zero", int'(count), 0);
    tick = 1; stat_rd = 1; cyc(); tick = 0; stat_rd = 0;
    chk("R9 set wins over read", int'(flag_wdt), 1);
    chk("R9 flag_stop stays clear", int'(flag_stop), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule